// File: doc/BRIEF.md
# Single-Word Burst Memory Bridge

This block lets slow user logic store and fetch individual data words in a burst-oriented DRAM whose controller runs on a clock of its own. On the user side a request carries a read/write flag, a word address and a write word. The block then holds `busy` until the access has finished. A read finishes with a one-cycle `rsp_valid` strobe carrying the word.

On the memory side every user access becomes exactly one command to a generic controller that always moves eight words. The user word address is shifted left by three, so each word owns a whole eight-word slot. Only lane 0 of the burst carries user data:
- On a write, the other seven lanes are driven to zero.
- On a read, the other seven lanes are discarded.

Requests and responses cross between the two clocks through small dual-clock FIFOs with Gray-coded pointers. Nothing is sent to the controller until it reports that calibration is complete. Only one access is in flight at a time, which is ample when the user needs one word roughly every 30 microseconds.

Top module: `sw_burst_bridge`

## Requirements
- R1: While `cal_done` is low, `cmd_valid` stays low. A request accepted before calibration waits, with `busy` held high, and is issued once `cal_done` rises.
- R2: The command address is the user word address shifted left by three bits: `cmd_addr[2:0]` is zero and `cmd_addr >> 3` equals `req_addr`.
- R3: For a write, lane 0 of `wr_data` (bits DW-1:0) holds the request's write word, and bits 8*DW-1:DW are all zero.
- R4: For a read, `rsp_rdata` equals lane 0 (bits DW-1:0) of the burst returned on `rd_data`. The other seven lanes have no effect on the result.
- R5: A request is accepted when `req_valid` is high while `busy` is low. `busy` is high from the user clock edge after acceptance until the access completes. Requests presented while `busy` is high are ignored: they issue no command and change no stored word.
- R6: A write completes without any `rsp_valid` pulse. `busy` falls once the memory has accepted both the command and the burst data.
- R7: A read completes with `rsp_valid` high for exactly one user cycle. On that same cycle `busy` is low.
- R8: At most one memory command is issued per accepted request. `cmd_valid` and `wr_valid` keep their values and payload stable until the controller accepts them.
- R9: After reset, `busy`, `rsp_valid`, `cmd_valid` and `wr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usr_clk | input | 1 | User-side clock |
| usr_rst_n | input | 1 | User-side synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | User word address |
| req_wdata | input | DW | Word to write |
| busy | output | 1 | Access in progress; new requests are ignored |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Read word |
| mem_clk | input | 1 | Memory controller clock |
| mem_rst_n | input | 1 | Memory-side synchronous active-low reset |
| cal_done | input | 1 | Controller calibration complete |
| cmd_valid | output | 1 | Command request |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | AW+3 | Burst-aligned memory address |
| cmd_ready | input | 1 | Controller accepts the command |
| wr_valid | output | 1 | Write burst data valid |
| wr_data | output | 8*DW | Write burst, lane 0 in the low bits |
| wr_ready | input | 1 | Controller accepts the write burst |
| rd_valid | input | 1 | Read burst valid |
| rd_data | input | 8*DW | Read burst, lane 0 in the low bits |

## Verification
`busy` is due on the first user edge after a request is sampled, so the bench drives on a falling edge and checks `busy` on the following falling edge. Completion depends on FIFO synchronizer latency in both domains and on the memory stub's randomized handshakes, so there is no fixed completion cycle. Instead the bench polls on each falling edge, within a bounded window, for `busy` to drop or `rsp_valid` to rise, and checks data and `busy` on that same cycle. Command address and burst contents are checked in the memory domain at the exact clock edge where each handshake completes. A read-back sweep after requests poked while busy shows that those requests changed nothing.

// File: rtl/sw_bridge_pkg.sv
// Package: shared constants and the memory-side state type for the
// single-word burst bridge. Assumes a fixed eight-word burst.
package sw_bridge_pkg;
    localparam int BURST_WORDS = 8;
    localparam int LANE_SHIFT  = 3;   // log2(BURST_WORDS)

    typedef enum logic [1:0] {
        MS_IDLE    = 2'd0,
        MS_ISSUE   = 2'd1,
        MS_WAIT_RD = 2'd2,
        MS_PUSH    = 2'd3
    } mem_state_t;
endpackage

// File: rtl/sw_bridge_afifo.sv
// Dual-clock FIFO with Gray-coded pointers and two-flop synchronizers.
// Full is produced in the write domain and empty in the read domain.
// Assumes callers gate wr_en with !full and rd_en with !empty; DEPTH_LOG2 >= 1.
module sw_bridge_afifo #(
    parameter int W          = 8,
    parameter int DEPTH_LOG2 = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PW    = DEPTH_LOG2 + 1;
    localparam logic [PW-1:0] FULL_X = PW'(3 << (DEPTH_LOG2 - 1));

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rg_q1, rg_q2, wg_q1, wg_q2;
    logic [PW-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + PW'(wr_en && !full);
    assign rbin_nx = rbin + PW'(rd_en && !empty);
    assign full    = (wgray == (rg_q2 ^ FULL_X));
    assign empty   = (rgray == wg_q2);
    assign rdata   = store[rbin[DEPTH_LOG2-1:0]];

    // Write pointer advance and synchronization of the read pointer.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rg_q1 <= '0;
            rg_q2 <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            rg_q1 <= rgray;
            rg_q2 <= rg_q1;
        end
    end

    // Storage write on an accepted push.
    always_ff @(posedge wclk) begin
        if (wr_en && !full) store[wbin[DEPTH_LOG2-1:0]] <= wdata;
    end

    // Read pointer advance and synchronization of the write pointer.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wg_q1 <= '0;
            wg_q2 <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            wg_q1 <= wgray;
            wg_q2 <= wg_q1;
        end
    end

    a_r8_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !full);
    a_r8_no_underflow: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/sw_bridge_user.sv
// User-domain front end: accepts one request at a time, holds busy until
// the response entry returns, and strobes read data. Assumes the response
// FIFO only fills while an access is outstanding.
module sw_bridge_user #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int EW = 1 + AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          q_push,
    output logic [EW-1:0] q_entry,
    input  logic          q_full,
    output logic          r_pop,
    input  logic [DW-1:0] r_data,
    input  logic          r_empty
);
    logic kind_wr;

    assign q_push  = req_valid && !busy && !q_full;
    assign q_entry = {req_write, req_addr, req_wdata};
    assign r_pop   = !r_empty;

    // Track the outstanding access and deliver its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            kind_wr   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (r_pop) begin
                busy      <= 1'b0;
                rsp_valid <= !kind_wr;
                rsp_rdata <= r_data;
            end else if (q_push) begin
                busy    <= 1'b1;
                kind_wr <= req_write;
            end
        end
    end

    a_r5_resp_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_pop |-> busy);
    a_r7_strobe_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!busy && $past(busy)));
endmodule

// File: rtl/sw_bridge_mem.sv
// Memory-domain sequencer: pops one request, issues one burst command
// (plus the write burst), waits for read data, and returns a response
// entry. Assumes cal_done never falls once it has risen.
module sw_bridge_mem
    import sw_bridge_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int EW  = 1 + AW + DW,
    localparam int MAW = AW + LANE_SHIFT,
    localparam int BW  = BURST_WORDS * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cal_done,
    output logic           q_pop,
    input  logic [EW-1:0]  q_entry,
    input  logic           q_empty,
    output logic           r_push,
    output logic [DW-1:0]  r_data,
    input  logic           r_full,
    output logic           cmd_valid,
    output logic           cmd_write,
    output logic [MAW-1:0] cmd_addr,
    input  logic           cmd_ready,
    output logic           wr_valid,
    output logic [BW-1:0]  wr_data,
    input  logic           wr_ready,
    input  logic           rd_valid,
    input  logic [BW-1:0]  rd_data
);
    mem_state_t    st;
    logic          is_wr, cmd_done, dat_done;
    logic [AW-1:0] addr_r;
    logic [DW-1:0] data_r, rd_word;
    logic          cmd_fire, wr_fire, cmd_ok, dat_ok;

    assign q_pop     = (st == MS_IDLE) && cal_done && !q_empty;
    assign cmd_valid = (st == MS_ISSUE) && !cmd_done;
    assign wr_valid  = (st == MS_ISSUE) && is_wr && !dat_done;
    assign cmd_write = is_wr;
    assign cmd_addr  = MAW'(addr_r) << LANE_SHIFT;
    assign wr_data   = {{(BW-DW){1'b0}}, data_r};
    assign r_push    = (st == MS_PUSH) && !r_full;
    assign r_data    = is_wr ? '0 : rd_word;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign wr_fire   = wr_valid && wr_ready;
    assign cmd_ok    = cmd_done || cmd_fire;
    assign dat_ok    = !is_wr || dat_done || wr_fire;

    // One access at a time: issue, wait for data, return a response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= MS_IDLE;
            is_wr    <= 1'b0;
            addr_r   <= '0;
            data_r   <= '0;
            rd_word  <= '0;
            cmd_done <= 1'b0;
            dat_done <= 1'b0;
        end else begin
            case (st)
                MS_IDLE: if (q_pop) begin
                    {is_wr, addr_r, data_r} <= q_entry;
                    cmd_done <= 1'b0;
                    dat_done <= 1'b0;
                    st       <= MS_ISSUE;
                end
                MS_ISSUE: begin
                    if (cmd_fire) cmd_done <= 1'b1;
                    if (wr_fire)  dat_done <= 1'b1;
                    if (cmd_ok && dat_ok) st <= is_wr ? MS_PUSH : MS_WAIT_RD;
                end
                MS_WAIT_RD: if (rd_valid) begin
                    rd_word <= rd_data[DW-1:0];
                    st      <= MS_PUSH;
                end
                default: if (!r_full) st <= MS_IDLE;
            endcase
        end
    end

    a_r1_no_cmd_before_cal: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> !cmd_valid);
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write)));
    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
endmodule

// File: rtl/sw_burst_bridge.sv
// Top: single-word access bridge onto an eight-word burst memory controller.
// A user-domain front end and a memory-domain sequencer are joined by a
// request FIFO and a response FIFO, each clocked on both sides.
// Assumes both resets are applied together.
module sw_burst_bridge
    import sw_bridge_pkg::*;
#(
    parameter int AW         = 4,
    parameter int DW         = 16,
    parameter int FIFO_DEPTH_LOG2 = 2,
    localparam int EW  = 1 + AW + DW,
    localparam int MAW = AW + LANE_SHIFT,
    localparam int BW  = BURST_WORDS * DW
) (
    input  logic           usr_clk,
    input  logic           usr_rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           busy,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    input  logic           mem_clk,
    input  logic           mem_rst_n,
    input  logic           cal_done,
    output logic           cmd_valid,
    output logic           cmd_write,
    output logic [MAW-1:0] cmd_addr,
    input  logic           cmd_ready,
    output logic           wr_valid,
    output logic [BW-1:0]  wr_data,
    input  logic           wr_ready,
    input  logic           rd_valid,
    input  logic [BW-1:0]  rd_data
);
    logic          q_push, q_full, q_pop, q_empty;
    logic [EW-1:0] q_in, q_out;
    logic          r_push, r_full, r_pop, r_empty;
    logic [DW-1:0] r_in, r_out;

    sw_bridge_user #(.AW(AW), .DW(DW)) u_user (
        .clk(usr_clk), .rst_n(usr_rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .q_push(q_push), .q_entry(q_in), .q_full(q_full),
        .r_pop(r_pop), .r_data(r_out), .r_empty(r_empty)
    );

    sw_bridge_afifo #(.W(EW), .DEPTH_LOG2(FIFO_DEPTH_LOG2)) u_req_fifo (
        .wclk(usr_clk), .wrst_n(usr_rst_n), .wr_en(q_push), .wdata(q_in), .full(q_full),
        .rclk(mem_clk), .rrst_n(mem_rst_n), .rd_en(q_pop), .rdata(q_out), .empty(q_empty)
    );

    sw_bridge_afifo #(.W(DW), .DEPTH_LOG2(FIFO_DEPTH_LOG2)) u_rsp_fifo (
        .wclk(mem_clk), .wrst_n(mem_rst_n), .wr_en(r_push), .wdata(r_in), .full(r_full),
        .rclk(usr_clk), .rrst_n(usr_rst_n), .rd_en(r_pop), .rdata(r_out), .empty(r_empty)
    );

    sw_bridge_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(mem_clk), .rst_n(mem_rst_n), .cal_done(cal_done),
        .q_pop(q_pop), .q_entry(q_out), .q_empty(q_empty),
        .r_push(r_push), .r_data(r_in), .r_full(r_full),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: tb/sw_burst_bridge_tb.sv
`timescale 1ns/100ps
// Bench: sweeps every word address with writes and reads against a
// behavioural eight-word burst memory on an unrelated clock.
module sw_burst_bridge_tb;
    localparam int AW = 4, DW = 16, NW = 1 << AW, BW = 8 * DW, MAW = AW + 3;

    logic usr_clk = 0, mem_clk = 0, usr_rst_n = 0, mem_rst_n = 0;
    logic req_valid = 0, req_write = 0, cal_done = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic busy, rsp_valid, cmd_valid, cmd_write, wr_valid;
    logic [DW-1:0] rsp_rdata;
    logic [MAW-1:0] cmd_addr;
    logic [BW-1:0] wr_data, rd_data;
    logic cmd_ready, wr_ready, rd_valid;

    always #2.5 usr_clk = ~usr_clk;   // 200 MHz user clock
    always #1.7 mem_clk = ~mem_clk;   // unrelated memory clock

    sw_burst_bridge #(.AW(AW), .DW(DW)) u_dut (.*);

    int n_chk = 0, n_fail = 0, n_req = 0, n_cmd = 0;
    bit done = 0, precal_cmd = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_data = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(16'hA5C3 ^ (a * 16'h1357));
    endfunction

    // Behavioural burst memory stub with pseudo-random handshakes.
    logic [DW-1:0] smem [NW];
    logic [3:0] sc;
    logic [2:0] rd_cnt;
    logic pend_rd;
    logic [AW-1:0] rd_a;
    assign cmd_ready = sc[1] ^ sc[3];
    assign wr_ready  = sc[0] | sc[2];
    always @(posedge mem_clk) begin
        if (!mem_rst_n) begin
            for (int i = 0; i < NW; i++) smem[i] <= '0;
            sc <= '0; rd_cnt <= '0; pend_rd <= 0; rd_a <= '0;
            rd_valid <= 0; rd_data <= '0;
        end else begin
            sc <= sc + 4'd3;
            rd_valid <= 0;
            if (!cal_done && cmd_valid) precal_cmd = 1;
            if (cmd_valid && cmd_ready) begin
                n_cmd++;
                chk(cmd_addr[2:0] == 3'b000 && (cmd_addr >> 3) == MAW'(exp_addr),
                    "R2 cmd_addr", cmd_addr, {exp_addr, 3'b000});
                if (!cmd_write) begin
                    pend_rd <= 1; rd_cnt <= 3'd3; rd_a <= cmd_addr[MAW-1:3];
                end
            end
            if (wr_valid && wr_ready) begin
                chk(wr_data[BW-1:DW] == '0, "R3 pad lanes", wr_data[BW-1:DW] != '0, 0);
                chk(wr_data[DW-1:0] == exp_data, "R3 lane0", wr_data[DW-1:0], exp_data);
                smem[exp_addr] <= wr_data[DW-1:0];
            end
            if (pend_rd) begin
                if (rd_cnt == 0) begin
                    pend_rd <= 0; rd_valid <= 1;
                    for (int k = 1; k < 8; k++) rd_data[k*DW +: DW] <= DW'(16'h1111 * k) ^ smem[rd_a];
                    rd_data[DW-1:0] <= smem[rd_a];
                end else rd_cnt <= rd_cnt - 1;
            end
        end
    end

    // Present one request; optionally poke an ignored request while busy.
    task automatic send(input bit wr, input int a, input logic [DW-1:0] d, input bit poke);
        exp_addr = AW'(a); exp_data = d;
        @(negedge usr_clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge usr_clk);
        n_req++;
        chk(busy == 1, "R5 busy after accept", busy, 1);
        if (poke) begin
            req_write = 1; req_addr = AW'(a) ^ 1; req_wdata = 16'hFFFF;
        end else req_valid = 0;
        @(negedge usr_clk);
        req_valid = 0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit poke);
        bit saw = 0; int t = 0;
        send(1, a, d, poke);
        while (busy && t < 1000) begin
            if (rsp_valid) saw = 1;
            @(negedge usr_clk); t++;
        end
        if (rsp_valid) saw = 1;
        chk(!busy, "R6 write completes", busy, 0);
        chk(!saw, "R6 no strobe on write", saw, 0);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] e, input bit poke);
        int t = 0;
        send(0, a, 16'h0, poke);
        while (!rsp_valid && t < 1000) begin @(negedge usr_clk); t++; end
        chk(rsp_valid, "R7 read strobe", rsp_valid, 1);
        chk(rsp_rdata == e, "R4 read lane0", rsp_rdata, e);
        chk(!busy, "R7 busy low with strobe", busy, 0);
        @(negedge usr_clk);
        chk(!rsp_valid, "R7 strobe one cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge usr_clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge usr_clk);
        usr_rst_n = 1; mem_rst_n = 1;
        @(negedge usr_clk);
        chk(!busy && !rsp_valid && !cmd_valid && !wr_valid, "R9 reset state",
            {busy, rsp_valid, cmd_valid, wr_valid}, 0);
        // R1: request before calibration must wait.
        send(1, 0, pat(0), 0);
        repeat (60) @(negedge usr_clk);
        chk(busy, "R1 waits for calibration", busy, 1);
        chk(!precal_cmd, "R1 no command before cal_done", precal_cmd, 0);
        cal_done = 1;
        for (int t = 0; t < 1000 && busy; t++) @(negedge usr_clk);
        chk(!busy, "R1 issued after cal_done", busy, 0);
        for (int a = 1; a < NW; a++) do_write(a, pat(a), a[0]);
        for (int a = 0; a < NW; a++) do_read(a, pat(a), 1);
        for (int a = NW - 1; a >= 0; a--) do_read(a, pat(a), 0);
        do_write(5, 16'h0000, 1);
        do_read(5, 16'h0000, 0);
        do_read(4, pat(4), 0);
        repeat (20) @(negedge usr_clk);
        chk(n_cmd == n_req, "R8 one command per accepted request", n_cmd, n_req);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule